// File: doc/BRIEF.md
# ASID-Tagged Address Translation Lookup

This block turns a 32-bit virtual address into a physical address. The top three address bits first pick a region. The control region at the top of the map passes the address through unchanged. Two privileged windows map to physical memory by clearing the top three bits. The user region and one privileged region are translated through a small fully associative TLB that works in 4 KB pages. Each TLB entry holds the following fields:
- a valid bit
- a virtual page number
- an 8-bit address space identifier (ASID)
- a shared flag
- a physical page number

A mode input selects how the ASID takes part in the tag match:
- In multiple virtual memory mode, the ASID separates processes that use the same virtual addresses. Changing the current ASID therefore needs no flush.
- In single virtual memory mode, the page number alone selects the entry. The ASID then serves only as a protection check.

Software refills entries through a write port. The port places each new entry in the next slot in round-robin order. Every lookup is answered one clock later with exactly one outcome:
- translated (the physical address is valid)
- TLB miss
- multiple hit
- protection violation

Top module: `asid_tlb_xlate`

## Requirements
- R1: A lookup presented with `req_valid` high at a rising edge is answered on the next rising edge with `rsp_valid` high. A cycle without a request gives `rsp_valid` low one edge later.
- R2: An address with bits [31:29] = 3'b111 is answered with `rsp_ok`=1 and `rsp_paddr` equal to the address, whatever the TLB holds.
- R3: An address with bits [31:29] equal to 3'b100 or 3'b101 is answered with `rsp_ok`=1 and `rsp_paddr` equal to the address with bits [31:29] cleared. The TLB is not consulted.
- R4: An address with bit 31 = 0, or with bits [31:29] = 3'b110, that matches exactly one entry is answered with `rsp_ok`=1. The response carries `rsp_paddr` = {1'b0, entry PPN[18:0], address[11:0]}.
- R5: A translated address that matches no entry is answered with `rsp_tlb_miss`=1, `rsp_ok`=0 and `rsp_paddr`=0.
- R6: In multiple mode (`vm_single`=0), an entry matches when all of these hold:
  - it is valid
  - its VPN equals address[31:12]
  - its shared bit is set, or its ASID equals the current ASID
- R7: In single mode (`vm_single`=1), an entry matches on valid and VPN alone. If the single matching entry is not shared, its ASID differs from the current ASID, and `req_priv`=0, the response is `rsp_prot_viol`=1 with `rsp_paddr`=0. With `req_priv`=1 the same lookup translates.
- R8: A translated lookup that matches two or more entries gives `rsp_multi_hit`=1 and `rsp_paddr`=0. This outcome takes precedence over a protection violation.
- R9: The current-ASID register resets to 0 and loads `asid_wdata` on a clock with `asid_we`=1, and it is read on `cur_asid`. Loading it leaves every entry's contents and valid state intact.
- R10: After reset all entries are invalid. Each `wr_en` clock writes a valid entry into slot 0, 1, … 7 and then wraps to slot 0. A written entry takes part in lookups from the next clock on.
- R11: Every response has exactly one of `rsp_ok`, `rsp_tlb_miss`, `rsp_multi_hit` or `rsp_prot_viol` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vm_single | input | 1 | 1 = single virtual memory mode, 0 = multiple |
| asid_we | input | 1 | Load the current-ASID register |
| asid_wdata | input | 8 | New current ASID |
| cur_asid | output | 8 | Current ASID register value |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_priv | input | 1 | Access is privileged |
| wr_en | input | 1 | Write one entry at the round-robin slot |
| wr_vpn | input | 20 | Virtual page number of the new entry |
| wr_asid | input | 8 | ASID of the new entry |
| wr_shared | input | 1 | Shared flag of the new entry |
| wr_ppn | input | 19 | Physical page number of the new entry |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | Physical address is valid |
| rsp_paddr | output | 32 | Physical address, zero on any fault |
| rsp_tlb_miss | output | 1 | No entry matched a translated address |
| rsp_multi_hit | output | 1 | More than one entry matched |
| rsp_prot_viol | output | 1 | Single-mode ASID protection fault |

## Verification
The assertions check the following on every cycle:
- response latency and the one-outcome rule
- zero address on any fault
- pass-through and fixed-window mapping of each request
- precedence of the multi-hit flag whenever the match vector shows more than one hit
- unchanged entry valid state across ASID loads

Only the bench scenarios can show the following, because each depends on a history of refills and ASID changes:
- which entry matches under each mode
- that the correct physical page comes back
- round-robin slot choice and its wrap
- that a protection fault turns into a translation for a privileged access

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  localparam int VA_W     = 32;
  localparam int PAGE_W   = 12;
  localparam int VPN_W    = VA_W - PAGE_W;
  localparam int ASID_W   = 8;
  localparam int PPN_W    = 19;
  localparam int PAD_W    = VA_W - PPN_W - PAGE_W;
  localparam int REGSEL_W = 3;

  typedef enum logic [1:0] {
    RGN_XLATE = 2'd0,
    RGN_FIXED = 2'd1,
    RGN_PASS  = 2'd2
  } region_e;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              shared;
    logic [PPN_W-1:0]  ppn;
  } tlb_entry_t;

  // Region from the top address bits.
  function automatic region_e decode_region(input logic [VA_W-1:0] va);
    logic [REGSEL_W-1:0] sel;
    sel = va[VA_W-1 -: REGSEL_W];
    case (sel)
      3'b100, 3'b101: return RGN_FIXED;
      3'b111:         return RGN_PASS;
      default:        return RGN_XLATE;
    endcase
  endfunction

  // Fixed window: drop the region selector bits.
  function automatic logic [VA_W-1:0] fixed_map(input logic [VA_W-1:0] va);
    return {{REGSEL_W{1'b0}}, va[VA_W-REGSEL_W-1:0]};
  endfunction

  // Physical address from page number and in-page offset.
  function automatic logic [VA_W-1:0] page_join(input logic [PPN_W-1:0] ppn,
                                                 input logic [PAGE_W-1:0] off);
    return {{PAD_W{1'b0}}, ppn, off};
  endfunction

  // Tag comparison: single mode ignores the ASID for selection.
  function automatic logic entry_tag_hit(input tlb_entry_t e,
                                         input logic [VPN_W-1:0] vpn,
                                         input logic [ASID_W-1:0] cur,
                                         input logic single);
    return e.valid && (e.vpn == vpn) && (single || e.shared || (e.asid == cur));
  endfunction

  // Owner check used for protection in single mode.
  function automatic logic asid_denied(input tlb_entry_t e,
                                       input logic [ASID_W-1:0] cur,
                                       input logic priv);
    return !e.shared && (e.asid != cur) && !priv;
  endfunction

endpackage

// File: rtl/tlb_region_decode.sv
module tlb_region_decode
  import asid_tlb_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  output region_e         region,
  output logic [VA_W-1:0] fixed_pa
);
  always_comb begin
    region   = decode_region(vaddr);
    fixed_pa = fixed_map(vaddr);
  end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  tlb_entry_t         wr_entry,
  input  logic [VPN_W-1:0]   look_vpn,
  input  logic [ASID_W-1:0]  cur_asid,
  input  logic               vm_single,
  input  logic               look_priv,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [PPN_W-1:0]   ppn_sel,
  output logic               deny_any
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0]   wr_ptr;
  tlb_entry_t         slot [ENTRIES];
  logic [PPN_W-1:0]   ppn_masked [ENTRIES];
  logic [ENTRIES-1:0] deny_vec;

  // Round-robin refill pointer.
  always_ff @(posedge clk) begin
    if (!rst_n)       wr_ptr <= '0;
    else if (wr_en)   wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                 slot[i] <= '0;
      else if (wr_en && (wr_ptr == PTR_W'(i)))    slot[i] <= wr_entry;
    end
    always_comb begin
      valid_vec[i]  = slot[i].valid;
      match_vec[i]  = entry_tag_hit(slot[i], look_vpn, cur_asid, vm_single);
      deny_vec[i]   = match_vec[i] && asid_denied(slot[i], cur_asid, look_priv);
      ppn_masked[i] = match_vec[i] ? slot[i].ppn : '0;
    end
  end

  always_comb begin
    ppn_sel = '0;
    for (int i = 0; i < ENTRIES; i++) ppn_sel = ppn_sel | ppn_masked[i];
    deny_any = |deny_vec;
  end
endmodule

// File: rtl/tlb_resp_stage.sv
module tlb_resp_stage
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  region_e            region,
  input  logic [VA_W-1:0]    fixed_pa,
  input  logic [ENTRIES-1:0] match_vec,
  input  logic [PPN_W-1:0]   ppn_sel,
  input  logic               deny_any,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic [VA_W-1:0]    rsp_paddr,
  output logic               rsp_tlb_miss,
  output logic               rsp_multi_hit,
  output logic               rsp_prot_viol
);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [CNT_W-1:0] n_match;
  logic             nx_ok, nx_miss, nx_multi, nx_prot;
  logic [VA_W-1:0]  nx_pa;

  always_comb begin
    n_match = '0;
    for (int i = 0; i < ENTRIES; i++) n_match = n_match + CNT_W'(match_vec[i]);
  end

  always_comb begin
    nx_ok = 1'b0; nx_miss = 1'b0; nx_multi = 1'b0; nx_prot = 1'b0;
    nx_pa = '0;
    case (region)
      RGN_PASS:  begin nx_ok = 1'b1; nx_pa = req_vaddr; end
      RGN_FIXED: begin nx_ok = 1'b1; nx_pa = fixed_pa;  end
      default: begin
        if (n_match > CNT_W'(1))       nx_multi = 1'b1;
        else if (n_match == '0)        nx_miss  = 1'b1;
        else if (deny_any)             nx_prot  = 1'b1;
        else begin
          nx_ok = 1'b1;
          nx_pa = page_join(ppn_sel, req_vaddr[PAGE_W-1:0]);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_ok <= 1'b0; rsp_paddr <= '0;
      rsp_tlb_miss <= 1'b0; rsp_multi_hit <= 1'b0; rsp_prot_viol <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_ok        <= req_valid && nx_ok;
      rsp_paddr     <= req_valid ? nx_pa : '0;
      rsp_tlb_miss  <= req_valid && nx_miss;
      rsp_multi_hit <= req_valid && nx_multi;
      rsp_prot_viol <= req_valid && nx_prot;
    end
  end
endmodule

// File: rtl/asid_tlb_xlate.sv
module asid_tlb_xlate
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vm_single,
  input  logic              asid_we,
  input  logic [ASID_W-1:0] asid_wdata,
  output logic [ASID_W-1:0] cur_asid,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_priv,
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_shared,
  input  logic [PPN_W-1:0]  wr_ppn,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic              rsp_tlb_miss,
  output logic              rsp_multi_hit,
  output logic              rsp_prot_viol
);
  region_e            req_region;
  logic [VA_W-1:0]    fixed_pa;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] slot_valid;
  logic [PPN_W-1:0]   ppn_sel;
  logic               deny_any;
  tlb_entry_t         new_entry;

  always_ff @(posedge clk) begin
    if (!rst_n)        cur_asid <= '0;
    else if (asid_we)  cur_asid <= asid_wdata;
  end

  always_comb begin
    new_entry.valid  = 1'b1;
    new_entry.vpn    = wr_vpn;
    new_entry.asid   = wr_asid;
    new_entry.shared = wr_shared;
    new_entry.ppn    = wr_ppn;
  end

  tlb_region_decode u_decode (
    .vaddr    (req_vaddr),
    .region   (req_region),
    .fixed_pa (fixed_pa)
  );

  tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_entry  (new_entry),
    .look_vpn  (req_vaddr[VA_W-1:PAGE_W]),
    .cur_asid  (cur_asid),
    .vm_single (vm_single),
    .look_priv (req_priv),
    .match_vec (hit_vec),
    .valid_vec (slot_valid),
    .ppn_sel   (ppn_sel),
    .deny_any  (deny_any)
  );

  tlb_resp_stage #(.ENTRIES(ENTRIES)) u_resp (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .region        (req_region),
    .fixed_pa      (fixed_pa),
    .match_vec     (hit_vec),
    .ppn_sel       (ppn_sel),
    .deny_any      (deny_any),
    .rsp_valid     (rsp_valid),
    .rsp_ok        (rsp_ok),
    .rsp_paddr     (rsp_paddr),
    .rsp_tlb_miss  (rsp_tlb_miss),
    .rsp_multi_hit (rsp_multi_hit),
    .rsp_prot_viol (rsp_prot_viol)
  );
endmodule

// File: rtl/asid_tlb_xlate_chk.sv
module asid_tlb_xlate_chk
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 8
)(
  input logic               clk,
  input logic               rst_n,
  input logic               asid_we,
  input logic               wr_en,
  input logic               req_valid,
  input logic [VA_W-1:0]    req_vaddr,
  input region_e            req_region,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] slot_valid,
  input logic               rsp_valid,
  input logic               rsp_ok,
  input logic [VA_W-1:0]    rsp_paddr,
  input logic               rsp_tlb_miss,
  input logic               rsp_multi_hit,
  input logic               rsp_prot_viol
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R1
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr[31:29] == 3'b111) |=> (rsp_ok && rsp_paddr == $past(req_vaddr))); // R2
  AST_FIXED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_vaddr[31:29] == 3'b100 || req_vaddr[31:29] == 3'b101))
      |=> (rsp_ok && rsp_paddr == {3'b000, $past(req_vaddr[28:0])})); // R3
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_paddr == '0)); // R5
  AST_MULTI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_region == RGN_XLATE && $countones(hit_vec) > 1) |=> rsp_multi_hit); // R8
  AST_ASID_KEEPS_ENTRIES: assert property (@(posedge clk) disable iff (!rst_n)
    (asid_we && !wr_en) |=> (slot_valid == $past(slot_valid))); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_ok, rsp_tlb_miss, rsp_multi_hit, rsp_prot_viol}) == 1)); // R11
endmodule

bind asid_tlb_xlate asid_tlb_xlate_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .asid_we       (asid_we),
  .wr_en         (wr_en),
  .req_valid     (req_valid),
  .req_vaddr     (req_vaddr),
  .req_region    (req_region),
  .hit_vec       (hit_vec),
  .slot_valid    (slot_valid),
  .rsp_valid     (rsp_valid),
  .rsp_ok        (rsp_ok),
  .rsp_paddr     (rsp_paddr),
  .rsp_tlb_miss  (rsp_tlb_miss),
  .rsp_multi_hit (rsp_multi_hit),
  .rsp_prot_viol (rsp_prot_viol)
);

// File: tb/asid_tlb_xlate_tb.sv
module asid_tlb_xlate_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vm_single = 1'b0;
  logic        asid_we = 1'b0;
  logic [7:0]  asid_wdata = '0;
  logic [7:0]  cur_asid;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_priv = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_vpn = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_shared = 1'b0;
  logic [18:0] wr_ppn = '0;
  logic        rsp_valid, rsp_ok, rsp_tlb_miss, rsp_multi_hit, rsp_prot_viol;
  logic [31:0] rsp_paddr;

  always #5 clk = ~clk;

  asid_tlb_xlate #(.ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .vm_single(vm_single),
    .asid_we(asid_we), .asid_wdata(asid_wdata), .cur_asid(cur_asid),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_priv(req_priv),
    .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_shared(wr_shared),
    .wr_ppn(wr_ppn), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_paddr(rsp_paddr), .rsp_tlb_miss(rsp_tlb_miss),
    .rsp_multi_hit(rsp_multi_hit), .rsp_prot_viol(rsp_prot_viol)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench-side model of the entry table and ASID register.
  bit        m_v [N];
  bit [19:0] m_vpn [N];
  bit [7:0]  m_asid [N];
  bit        m_sh [N];
  bit [18:0] m_ppn [N];
  int        m_ptr = 0;
  bit [7:0]  m_cur = 0;

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_ptr = 0; m_cur = 0;
  endtask

  task automatic put(input bit [19:0] vpn, input bit [7:0] asid, input bit sh, input bit [18:0] ppn);
    @(negedge clk);
    wr_en = 1; wr_vpn = vpn; wr_asid = asid; wr_shared = sh; wr_ppn = ppn;
    @(negedge clk);
    wr_en = 0;
    m_v[m_ptr] = 1; m_vpn[m_ptr] = vpn; m_asid[m_ptr] = asid;
    m_sh[m_ptr] = sh; m_ppn[m_ptr] = ppn;
    m_ptr = (m_ptr + 1) % N;
  endtask

  task automatic set_asid(input bit [7:0] a, input string tag);
    @(negedge clk);
    asid_we = 1; asid_wdata = a;
    @(negedge clk);
    asid_we = 0; m_cur = a;
    chk(cur_asid == a, tag, "cur_asid", {24'b0, cur_asid}, {24'b0, a});
  endtask

  // One lookup, compared against the requirement-level model.
  task automatic lookup(input bit [31:0] va, input bit priv, input string tag);
    bit e_ok, e_miss, e_multi, e_prot;
    bit [31:0] e_pa;
    int cnt, hit_i;
    e_ok = 0; e_miss = 0; e_multi = 0; e_prot = 0; e_pa = 0; cnt = 0; hit_i = 0;
    if (va >= 32'hE000_0000) begin
      e_ok = 1; e_pa = va;
    end else if (va >= 32'h8000_0000 && va < 32'hC000_0000) begin
      e_ok = 1; e_pa = va & 32'h1FFF_FFFF;
    end else begin
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_vpn[i] == va[31:12] &&
            (vm_single || m_sh[i] || m_asid[i] == m_cur)) begin
          cnt++; hit_i = i;
        end
      if (cnt > 1) e_multi = 1;
      else if (cnt == 0) e_miss = 1;
      else if (vm_single && !m_sh[hit_i] && m_asid[hit_i] != m_cur && !priv) e_prot = 1;
      else begin
        e_ok = 1; e_pa = (32'(m_ppn[hit_i]) << 12) | (va & 32'hFFF);
      end
    end
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_priv = priv;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1'b1, tag, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
    chk({rsp_ok, rsp_tlb_miss, rsp_multi_hit, rsp_prot_viol} == {e_ok, e_miss, e_multi, e_prot},
        tag, "flags ok/miss/multi/prot",
        {28'b0, rsp_ok, rsp_tlb_miss, rsp_multi_hit, rsp_prot_viol},
        {28'b0, e_ok, e_miss, e_multi, e_prot});
    chk(rsp_paddr == e_pa, tag, "paddr", rsp_paddr, e_pa);
    chk($countones({rsp_ok, rsp_tlb_miss, rsp_multi_hit, rsp_prot_viol}) == 1, "R11",
        "outcome count", 32'($countones({rsp_ok, rsp_tlb_miss, rsp_multi_hit, rsp_prot_viol})), 32'd1);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic t_reset_state();
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 0);
    chk(cur_asid == 0, "R9", "cur_asid after reset", {24'b0, cur_asid}, 0);
    lookup(32'h0000_1234, 0, "R10");   // every slot invalid: miss
    lookup(32'hC000_0010, 1, "R10");
  endtask

  task automatic t_latency();
    lookup(32'hE000_0004, 0, "R1");
    @(negedge clk);                    // idle cycle: no response
    chk(rsp_valid == 0, "R1", "idle rsp_valid", {31'b0, rsp_valid}, 0);
  endtask

  task automatic t_pass_fixed();
    put(20'hE0001, 8'h00, 0, 19'h7_1111); // entry matching top region must be ignored
    lookup(32'hE000_1ABC, 0, "R2");
    lookup(32'hFFFF_FFFF, 1, "R2");
    lookup(32'h8123_4567, 0, "R3");
    lookup(32'hBFFF_FFFC, 1, "R3");
    lookup(32'hA000_0000, 0, "R3");
  endtask

  task automatic t_multi_mode();
    vm_single = 0;
    put(20'h00012, 8'h05, 0, 19'h1_2345);
    put(20'hC0003, 8'h05, 0, 19'h0_0ABC);
    put(20'h00040, 8'h09, 1, 19'h4_0404);
    set_asid(8'h05, "R9");
    lookup(32'h0001_2FA0, 0, "R4");
    lookup(32'hC000_3008, 1, "R4");
    lookup(32'h0004_0001, 0, "R6");  // shared entry, foreign ASID
    lookup(32'h0777_7000, 0, "R5");  // no such page
    set_asid(8'h06, "R9");
    lookup(32'h0001_2FA0, 0, "R6");  // ASID mismatch: miss
    lookup(32'h0004_0002, 0, "R6");  // shared still hits
    set_asid(8'h05, "R9");
    lookup(32'h0001_2000, 0, "R9");  // entry survived the switch
  endtask

  task automatic t_single_mode();
    vm_single = 1;
    set_asid(8'h06, "R9");
    lookup(32'h0001_2FA0, 0, "R7");  // foreign non-shared, user: protection
    lookup(32'h0001_2FA0, 1, "R7");  // privileged: translates
    lookup(32'h0004_0FFF, 0, "R7");  // shared: translates
    set_asid(8'h05, "R7");
    lookup(32'h0001_2FA0, 0, "R7");  // own ASID: translates
  endtask

  task automatic t_multi_hit();
    put(20'h00055, 8'h01, 0, 19'h0_5501);
    put(20'h00055, 8'h02, 0, 19'h0_5502);
    vm_single = 1;
    lookup(32'h0005_5000, 0, "R8");  // two by VPN, also would be protection
    vm_single = 0;
    set_asid(8'h01, "R8");
    lookup(32'h0005_5004, 0, "R8");  // only one by ASID
    put(20'h00055, 8'h03, 1, 19'h0_5503);
    lookup(32'h0005_5008, 0, "R8");  // shared duplicate: multi
  endtask

  task automatic t_round_robin();
    do_reset();
    vm_single = 0;
    for (int i = 0; i < N; i++) put(20'h00100 + 20'(i), 8'h00, 0, 19'h0_0100 + 19'(i));
    lookup(32'h0010_0000, 0, "R10");
    lookup(32'h0010_7000, 0, "R10");
    put(20'h00200, 8'h00, 0, 19'h0_0200); // wraps onto slot 0
    lookup(32'h0010_0000, 0, "R10");       // evicted: miss
    lookup(32'h0020_0123, 0, "R10");
    lookup(32'h0010_1000, 0, "R10");       // slot 1 untouched
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset_state();
    t_latency();
    t_pass_fixed();
    t_multi_mode();
    t_single_mode();
    t_multi_hit();
    t_round_robin();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule